// File: doc/BRIEF.md
# Sequential Shift-Add Significand Multiplier

This unit multiplies two 113-bit significands over many clock cycles. Each operand sits in a 128-bit field built from four 32-bit words, with its leading one at bit 112 (bit 16 of the top word). A 128-bit accumulator is shifted right by one place for each multiplier bit, working upward from the least significant bit. After the shift the multiplicand is added whenever that multiplier bit is one. Bits that fall off the low end are kept as a round bit, which holds the most recent bit dropped, and a sticky bit, which is the OR of every bit dropped before it.

Zero multiplier words are cheap. A zero bottom word costs one idle cycle and no shift. A zero word in the middle of the multiplier costs one cycle that shifts the accumulator right by a whole word. The top word is only walked as far as its highest set bit. When the last step is done, a product at or above 2^113 is shifted right one more place and its exponent sum is increased by one. The result and the exponent sum are then held until the next accepted start.

Top module: `sam_mul`

## Requirements
- R1: During reset and in the first idle cycle after it, busy_o and done_o are 0, and sig_o, exp_o, rnd_o and stk_o are all 0.
- R2: For multiplicand x and multiplier y, with P = x*y as an exact 256-bit product, sig_o equals P>>112 when P[225] is 0 and P>>113 when P[225] is 1.
- R3: rnd_o is P[111] and stk_o is the OR of P[110:0] in the unshifted case. In the shifted case rnd_o is P[112] and stk_o is the OR of P[111:0].
- R4: exp_o is x_exp_i+y_exp_i (32-bit two's complement) when the accumulator ends below 2^113, and one more than that otherwise. In both cases the leading one of sig_o is at bit 112.
- R5: done_o rises exactly c0+c1+c2+c3 rising edges after the edge that accepts start. Here c0, c1 and c2 are 1 for a zero multiplier word and 32 otherwise (words at bits 31:0, 63:32 and 95:64), and c3 is one more than the index of the highest set bit of y[127:96].
- R6: busy_o is 1 from the cycle after an accepted start until done_o. done_o is high for exactly one cycle, and busy_o is 0 in that cycle.
- R7: A start asserted while busy_o is 1 is ignored. The running operation keeps its operands, its result and its latency.
- R8: sig_o, exp_o, rnd_o and stk_o do not change from the done pulse until the next accepted start, even if the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiply; taken only when idle |
| x_sig_i | input | 128 | Multiplicand significand, leading one at bit 112 |
| y_sig_i | input | 128 | Multiplier significand, leading one at bit 112 |
| x_exp_i | input | 32 | Multiplicand exponent, signed |
| y_exp_i | input | 32 | Multiplier exponent, signed |
| busy_o | output | 1 | High while a multiply is running |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| sig_o | output | 128 | Normalized product significand |
| exp_o | output | 32 | Exponent sum, plus one if normalized by a shift |
| rnd_o | output | 1 | Most recent bit dropped below the result |
| stk_o | output | 1 | OR of all earlier dropped bits |

## Verification
The final add and the normalization shift happen in the same clock edge. The sum from the last multiplier bit feeds the 2^113 comparison directly. That shift moves the round bit into sticky and captures a new round bit, while the exponent gains its increment. Operand pairs whose product lands above 2 (all-ones significands, 1.5 times 1.5) exercise this path, and others land just below it. Every result is judged against an exact 256-bit product computed in the bench, and the exponent, round and sticky bits are checked on the same done pulse.

// File: rtl/sam_pkg.sv
package sam_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sam_state_e;

    typedef enum logic [1:0] {
        SK_HOLD = 2'd0,
        SK_BIT  = 2'd1,
        SK_JUMP = 2'd2
    } sam_step_e;

endpackage

// File: rtl/sam_step.sv
// One accumulator step: hold, single-bit shift with conditional add, or whole-word jump.
module sam_step
    import sam_pkg::*;
#(
    parameter int SIG_W  = 128,
    parameter int WORD_W = 32
) (
    input  logic [SIG_W-1:0] acc_i,
    input  logic [SIG_W-1:0] mcand_i,
    input  logic             rnd_i,
    input  logic             stk_i,
    input  logic             ybit_i,
    input  sam_step_e        kind_i,
    output logic [SIG_W-1:0] acc_o,
    output logic             rnd_o,
    output logic             stk_o
);

    logic [SIG_W-1:0] shifted;
    logic [SIG_W-1:0] addend;

    always_comb begin
        shifted = acc_i >> 1;
        addend  = ybit_i ? mcand_i : '0;
        acc_o   = acc_i;
        rnd_o   = rnd_i;
        stk_o   = stk_i;
        case (kind_i)
            SK_BIT: begin
                stk_o = stk_i | rnd_i;
                rnd_o = acc_i[0];
                acc_o = shifted + addend;
            end
            SK_JUMP: begin
                stk_o = stk_i | rnd_i | (|acc_i[WORD_W-2:0]);
                rnd_o = acc_i[WORD_W-1];
                acc_o = acc_i >> WORD_W;
            end
            default: begin
                acc_o = acc_i;
            end
        endcase
    end

endmodule

// File: rtl/sam_norm.sv
// Final normalization: one extra right shift when the product reaches 2^LIMIT.
module sam_norm #(
    parameter int SIG_W = 128,
    parameter int LIMIT = 113
) (
    input  logic [SIG_W-1:0] acc_i,
    input  logic             rnd_i,
    input  logic             stk_i,
    output logic [SIG_W-1:0] sig_o,
    output logic             rnd_o,
    output logic             stk_o,
    output logic             inc_o
);

    always_comb begin
        inc_o = |acc_i[SIG_W-1:LIMIT];
        if (inc_o) begin
            sig_o = acc_i >> 1;
            rnd_o = acc_i[0];
            stk_o = stk_i | rnd_i;
        end else begin
            sig_o = acc_i;
            rnd_o = rnd_i;
            stk_o = stk_i;
        end
    end

endmodule

// File: rtl/sam_msb.sv
// Index of the highest set bit of a word (0 for an all-zero word).
module sam_msb #(
    parameter int WORD_W = 32,
    localparam int IW    = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [IW-1:0]     pos_o
);

    always_comb begin
        pos_o = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (word_i[i]) pos_o = IW'(i);
        end
    end

endmodule

// File: rtl/sam_mul.sv
module sam_mul
    import sam_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int N_WORDS  = 4,
    parameter int EXP_W    = 32,
    parameter int LEAD_BIT = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_i,
    input  logic [WORD_W*N_WORDS-1:0]       x_sig_i,
    input  logic [WORD_W*N_WORDS-1:0]       y_sig_i,
    input  logic signed [EXP_W-1:0]         x_exp_i,
    input  logic signed [EXP_W-1:0]         y_exp_i,
    output logic                            busy_o,
    output logic                            done_o,
    output logic [WORD_W*N_WORDS-1:0]       sig_o,
    output logic signed [EXP_W-1:0]         exp_o,
    output logic                            rnd_o,
    output logic                            stk_o
);

    localparam int SIG_W    = WORD_W * N_WORDS;
    localparam int BI_W     = $clog2(WORD_W);
    localparam int WI_W     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam int LEAD_POS = (N_WORDS - 1) * WORD_W + LEAD_BIT;
    localparam logic [WI_W-1:0] TOP_IDX  = WI_W'(N_WORDS - 1);
    localparam logic [BI_W-1:0] LAST_BIT = BI_W'(WORD_W - 1);

    typedef struct packed {
        sam_state_e        st;
        logic [SIG_W-1:0]  acc;
        logic [SIG_W-1:0]  mcand;
        logic [SIG_W-1:0]  mplier;
        logic              rnd;
        logic              stk;
        logic [WI_W-1:0]   widx;
        logic [BI_W-1:0]   bidx;
        logic [EXP_W-1:0]  esum;
        logic [SIG_W-1:0]  res_sig;
        logic [EXP_W-1:0]  res_exp;
        logic              res_rnd;
        logic              res_stk;
        logic              done;
    } regs_t;

    regs_t d, q;

    logic [WORD_W-1:0] yword [N_WORDS];
    logic [WORD_W-1:0] cur_word;
    logic [BI_W-1:0]   top_msb;
    logic              word_zero, at_bottom, at_top, first_bit, last_bit, word_end, finish;
    sam_step_e         kind;
    logic [SIG_W-1:0]  st_acc, nm_sig;
    logic              st_rnd, st_stk, nm_rnd, nm_stk, nm_inc;

    for (genvar g = 0; g < N_WORDS; g++) begin : g_words
        assign yword[g] = q.mplier[g*WORD_W +: WORD_W];
    end

    assign cur_word = yword[q.widx];

    sam_msb #(.WORD_W(WORD_W)) u_msb (
        .word_i (yword[N_WORDS-1]),
        .pos_o  (top_msb)
    );

    always_comb begin
        word_zero = (cur_word == '0);
        at_bottom = (q.widx == '0);
        at_top    = (q.widx == TOP_IDX);
        first_bit = (q.bidx == '0);
        if (first_bit && word_zero && at_bottom && !at_top) begin
            kind = SK_HOLD;
        end else if (first_bit && word_zero && !at_top) begin
            kind = SK_JUMP;
        end else begin
            kind = SK_BIT;
        end
        last_bit = at_top ? (q.bidx == top_msb) : (q.bidx == LAST_BIT);
        word_end = (kind != SK_BIT) || last_bit;
        finish   = at_top && last_bit && (kind == SK_BIT);
    end

    sam_step #(.SIG_W(SIG_W), .WORD_W(WORD_W)) u_step (
        .acc_i   (q.acc),
        .mcand_i (q.mcand),
        .rnd_i   (q.rnd),
        .stk_i   (q.stk),
        .ybit_i  (cur_word[q.bidx]),
        .kind_i  (kind),
        .acc_o   (st_acc),
        .rnd_o   (st_rnd),
        .stk_o   (st_stk)
    );

    sam_norm #(.SIG_W(SIG_W), .LIMIT(LEAD_POS + 1)) u_norm (
        .acc_i (st_acc),
        .rnd_i (st_rnd),
        .stk_i (st_stk),
        .sig_o (nm_sig),
        .rnd_o (nm_rnd),
        .stk_o (nm_stk),
        .inc_o (nm_inc)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st     = ST_RUN;
                    d.acc    = '0;
                    d.rnd    = 1'b0;
                    d.stk    = 1'b0;
                    d.mcand  = x_sig_i;
                    d.mplier = y_sig_i;
                    d.widx   = '0;
                    d.bidx   = '0;
                    d.esum   = x_exp_i + y_exp_i;
                end
            end
            ST_RUN: begin
                d.acc = st_acc;
                d.rnd = st_rnd;
                d.stk = st_stk;
                if (finish) begin
                    d.st      = ST_IDLE;
                    d.res_sig = nm_sig;
                    d.res_rnd = nm_rnd;
                    d.res_stk = nm_stk;
                    d.res_exp = q.esum + EXP_W'(nm_inc);
                    d.done    = 1'b1;
                end else if (word_end) begin
                    d.widx = q.widx + 1'b1;
                    d.bidx = '0;
                end else begin
                    d.bidx = q.bidx + 1'b1;
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.st == ST_RUN);
    assign done_o = q.done;
    assign sig_o  = q.res_sig;
    assign exp_o  = q.res_exp;
    assign rnd_o  = q.res_rnd;
    assign stk_o  = q.res_stk;

endmodule

// File: rtl/sam_mul_chk.sv
module sam_mul_chk #(
    parameter int WORD_W   = 32,
    parameter int N_WORDS  = 4,
    parameter int EXP_W    = 32,
    parameter int LEAD_BIT = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_i,
    input logic                      busy_o,
    input logic                      done_o,
    input logic [WORD_W*N_WORDS-1:0] sig_o,
    input logic [EXP_W-1:0]          exp_o,
    input logic                      rnd_o,
    input logic                      stk_o
);

    localparam int SIG_W    = WORD_W * N_WORDS;
    localparam int LEAD_POS = (N_WORDS - 1) * WORD_W + LEAD_BIT;
    localparam int MAX_LAT  = N_WORDS * WORD_W;
    localparam int LAT_W    = $clog2(MAX_LAT + 2) + 1;

    logic [LAT_W-1:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lat_q <= '0;
        else if (busy_o) lat_q <= lat_q + 1'b1;
        else             lat_q <= '0;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R6
    AST_START_ENTERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);  // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));  // R6
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));  // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(sig_o) && $stable(exp_o) && $stable(rnd_o) && $stable(stk_o)));  // R8
    AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sig_o[LEAD_POS] && ((sig_o >> (LEAD_POS + 1)) == '0)));  // R4
    AST_MAX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q <= LAT_W'(MAX_LAT));  // R5

endmodule

bind sam_mul sam_mul_chk #(
    .WORD_W   (WORD_W),
    .N_WORDS  (N_WORDS),
    .EXP_W    (EXP_W),
    .LEAD_BIT (LEAD_BIT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sig_o   (sig_o),
    .exp_o   (exp_o),
    .rnd_o   (rnd_o),
    .stk_o   (stk_o)
);

// File: tb/tb_sam_mul.sv
`timescale 1ns/1ps
module tb_sam_mul;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic [127:0] x_sig_i, y_sig_i;
    logic signed [31:0] x_exp_i, y_exp_i;
    logic         busy_o, done_o, rnd_o, stk_o;
    logic [127:0] sig_o;
    logic signed [31:0] exp_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    sam_mul dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .x_sig_i(x_sig_i), .y_sig_i(y_sig_i), .x_exp_i(x_exp_i), .y_exp_i(y_exp_i),
        .busy_o(busy_o), .done_o(done_o), .sig_o(sig_o), .exp_o(exp_o),
        .rnd_o(rnd_o), .stk_o(stk_o)
    );

    localparam int NV = 7;
    localparam logic [127:0] XV [NV] = '{
        128'h00010000_00000000_00000000_00000000,
        128'h0001FFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
        128'h00010000_00000000_00000000_00000001,
        128'h0001FFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
        128'h00011234_56789ABC_DEF01234_80000000,
        128'h00015555_AAAAAAAA_55555555_AAAAAAAA,
        128'h00017FFF_FFFFFFFF_FFFFFFFF_FFFFFFFF};
    localparam logic [127:0] YV [NV] = '{
        128'h00010000_00000000_00000000_00000000,
        128'h0001FFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
        128'h00010000_00000000_00000000_00000003,
        128'h00018000_00000000_DEADBEEF_00000000,
        128'h0001FFFF_00000000_80000000_00000001,
        128'h00010001_FFFFFFFF_00000000_00000000,
        128'h00018000_00000000_00000000_00000000};
    localparam int EXV [NV] = '{3, 10, -1, 100, -200, 0, 7};
    localparam int EYV [NV] = '{-5, 20, -1, -50, -3, 0, -7};
    localparam int CYV [NV] = '{20, 113, 51, 51, 82, 51, 20};

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [127:0] x, input logic [127:0] y, input int ex, input int ey,
                         output logic [127:0] sig, output logic r, output logic s, output int e);
        logic [255:0] p;
        p = {128'b0, x} * {128'b0, y};
        if (p[225]) begin
            sig = p[240:113]; r = p[112]; s = |p[111:0]; e = ex + ey + 1;
        end else begin
            sig = p[239:112]; r = p[111]; s = |p[110:0]; e = ex + ey;
        end
    endtask

    task automatic run_op(input logic [127:0] x, input logic [127:0] y, input int ex, input int ey,
                          input int inj_at, output int cyc);
        @(negedge clk);
        x_sig_i = x; y_sig_i = y; x_exp_i = ex; y_exp_i = ey;
        start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        chk("R6 busy after start", {255'b0, busy_o}, 256'd1);
        cyc = 0;
        while (1) begin
            @(posedge clk);
            cyc++;
            #1;
            if (done_o) break;
            if (inj_at != 0 && cyc == inj_at) begin
                start_i = 1'b1;
                x_sig_i = XV[0]; y_sig_i = YV[5]; x_exp_i = 1; y_exp_i = 1;
            end else begin
                start_i = 1'b0;
            end
            if (cyc > 1000) begin
                n_tests++; n_fail++;
                $display("FAIL R5 no done actual=%0d expected<=128", cyc);
                break;
            end
        end
        start_i = 1'b0;
    endtask

    task automatic check_result(input string tag, input int i, input int cyc);
        logic [127:0] es; logic er, ess; int ee;
        model(XV[i], YV[i], EXV[i], EYV[i], es, er, ess, ee);
        chk({"R2 sig ", tag}, {128'b0, sig_o}, {128'b0, es});
        chk({"R3 rnd ", tag}, {255'b0, rnd_o}, {255'b0, er});
        chk({"R3 stk ", tag}, {255'b0, stk_o}, {255'b0, ess});
        chk({"R4 exp ", tag}, {224'b0, exp_o}, {224'b0, ee[31:0]});
        chk({"R5 cycles ", tag}, {224'b0, cyc[31:0]}, {224'b0, CYV[i][31:0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        logic [127:0] held_sig;
        logic [31:0]  held_exp;
        rst_n = 1'b0; start_i = 1'b0;
        x_sig_i = '0; y_sig_i = '0; x_exp_i = '0; y_exp_i = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset busy/done", {254'b0, busy_o, done_o}, 256'd0);
        chk("R1 reset sig", {128'b0, sig_o}, 256'd0);
        chk("R1 reset exp/rnd/stk", {222'b0, exp_o, rnd_o, stk_o}, 256'd0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 idle after reset", {222'b0, busy_o, done_o, rnd_o, stk_o, exp_o}, 256'd0);

        for (int i = 0; i < NV; i++) begin
            run_op(XV[i], YV[i], EXV[i], EYV[i], 0, cyc);
            check_result($sformatf("vec%0d", i), i, cyc);
            chk("R6 done while idle", {255'b0, busy_o}, 256'd0);
            @(posedge clk);
            #1;
            chk("R6 done one cycle", {255'b0, done_o}, 256'd0);
        end

        // R7: a start raised mid-run must not disturb the running multiply
        run_op(XV[1], YV[1], EXV[1], EYV[1], 5, cyc);
        check_result("R7 start ignored", 1, cyc);

        // R8: results hold while idle even if operand inputs move
        held_sig = sig_o;
        held_exp = exp_o;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            x_sig_i = XV[k % NV]; y_sig_i = YV[(k + 3) % NV]; x_exp_i = k; y_exp_i = -k;
        end
        @(posedge clk);
        #1;
        chk("R8 sig held", {128'b0, sig_o}, {128'b0, held_sig});
        chk("R8 exp held", {224'b0, exp_o}, {224'b0, held_exp});
        chk("R8 no spurious done", {254'b0, done_o, busy_o}, 256'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule